// File: doc/BRIEF.md
# SMBus Alert Responder

This block is the device side of the SMBus alert mechanism. It watches a vector of fault and warning status bits. Each bit is captured into a sticky status register. When a bit that the enable mask selects goes from 0 to 1 and was not already latched, the block pulls its open-drain alert line low. The alert line is an output that the host's interrupt input monitors together with the alert lines of other devices.

When the host reads from the alert response address, the block acknowledges only if its alert is pending. It then returns its own 7-bit address, most significant bit first, on an open-drain SDA line. Several responders may transmit at once. Each one compares the bus level with the bit it released, and a device that released a 1 but sees a 0 stops driving. Because of this, the lowest address wins the data byte. Only the winner releases its alert, during the NACK bit that follows the byte. A losing device keeps its alert asserted, and the host repeats the read until the line goes high.

The latched status stays unchanged after a successful response until a host clear strobe zeroes it. After a clear, any enabled bit that is still high counts as a new rise and raises a fresh alert.

Top module: `smb_alert_resp`

## Requirements
- R1: Out of reset the alert, the SDA pull-down and the latched status are all 0. The latched status takes the OR of itself and `status_i` at each clock edge. `alert_pull_o` is 1 one clock edge after an enabled status bit is high while its latched copy is 0.
- R2: A status bit whose enable bit is 0 is latched into the status register but never asserts the alert.
- R3: The address byte 0x19 (address 0x0C with the read bit set to 1) is acknowledged only while the alert is pending. The block holds SDA low from the SCL falling edge after the 8th address bit until the SCL falling edge after the 9th.
- R4: The data byte is the device address in bits 7..1 and a released 1 in bit 0. It is sent MSB first, and each bit changes after an SCL falling edge.
- R5: A device that wins releases its alert before SCL rises for the NACK bit that follows the data byte.
- R6: After a win, the alert stays released and the latched status stays unchanged while the status inputs are steady and no clear arrives.
- R7: A status bit that is already latched does not raise the alert again, even if it toggles. A different enabled bit that rises does raise it.
- R8: If the block releases SDA for a data bit in 7..1 and samples it low on the SCL rising edge, it drives no further bits of that byte and keeps its alert asserted. Under concurrent responses, the lower address is the byte the host reads.
- R9: SDA is never driven when the address byte differs from 0x19 or when no alert is pending. A drive still in progress when the alert drops is released at the next clock edge.
- R10: A clear strobe zeroes the latched status and the alert at the next clock edge. An enabled bit that is still high then raises the alert again one edge later.
- R11: A STOP or a repeated START aborts any transfer: SDA is released, the alert is unchanged, and the next read of 0x19 is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling SCL and SDA |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| status_i | input | N_STATUS | Live fault and warning status bits |
| enable_i | input | N_STATUS | Per-bit alert enable mask |
| dev_addr_i | input | 7 | This device's 7-bit address |
| clear_i | input | 1 | Host strobe that zeroes latched status |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| alert_pull_o | output | 1 | 1 pulls the alert line low (alert pending) |
| status_q_o | output | N_STATUS | Latched status bits |

## Verification
Status capture and alert assertion are due one clock edge after the stimulus. A clear is visible after one edge, and the re-raised alert one edge after that. SDA responses trail a bus-line change by three clock edges: two synchronizer flops and the output register. The bench therefore holds each SCL phase for eight clocks and samples SDA and the alert halfway through the SCL-high phase, where every response is already settled. The latched status is compared against a behavioural model on every falling clock edge.

// File: rtl/smba_pkg.sv
package smba_pkg;

    localparam int          ADDR_W    = 7;
    localparam int          BYTE_W    = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] RESP_ADDR = 7'h0C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ACK,
        ST_DATA,
        ST_NACK
    } resp_st_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [BYTE_W-1:0] resp_addr_byte();
        return {RESP_ADDR, 1'b1};
    endfunction

    function automatic logic [BYTE_W-1:0] reply_byte(input logic [ADDR_W-1:0] a);
        return {a, 1'b1};
    endfunction

endpackage

// File: rtl/smba_sync.sv
module smba_sync
    import smba_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_pipe, sda_pipe;
    logic         scl_d, sda_d;
    logic         scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_d    <= scl_pipe[TOP];
            sda_d    <= sda_pipe[TOP];
        end
    end

    assign scl_s = scl_pipe[TOP];
    assign sda_s = sda_pipe[TOP];

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/smba_status.sv
module smba_status #(
    parameter int N_STATUS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_STATUS-1:0] status_i,
    input  logic [N_STATUS-1:0] enable_i,
    input  logic                clear_i,
    input  logic                win_i,
    output logic [N_STATUS-1:0] status_q_o,
    output logic                pending_o
);
    logic [N_STATUS-1:0] fresh;
    logic                raise;

    always_comb begin
        fresh = status_i & enable_i & ~status_q_o;
        raise = |fresh;
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            status_q_o <= '0;
            pending_o  <= 1'b0;
        end else begin
            status_q_o <= status_q_o | status_i;
            if (raise)
                pending_o <= 1'b1;
            else if (win_i)
                pending_o <= 1'b0;
        end
    end
endmodule

// File: rtl/smba_fsm.sv
module smba_fsm
    import smba_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              pending_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    output logic              sda_pull_o,
    output logic              win_o
);
    resp_st_e          st;
    logic [2:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            tx         <= '1;
            sda_pull_o <= 1'b0;
            win_o      <= 1'b0;
        end else begin
            win_o <= 1'b0;
            if (ev.start) begin
                st         <= ST_ADDR;
                cnt        <= '0;
                sda_pull_o <= 1'b0;
            end else if (ev.stop) begin
                st         <= ST_IDLE;
                sda_pull_o <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: if (ev.scl_rise) begin
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                        if (cnt == 3'd7) st <= ST_ADDR_END;
                        else             cnt <= cnt + 3'd1;
                    end
                    ST_ADDR_END: if (ev.scl_fall) begin
                        if (shreg == resp_addr_byte() && pending_i) begin
                            sda_pull_o <= 1'b1;
                            st         <= ST_ACK;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_ACK: if (!pending_i) begin
                        sda_pull_o <= 1'b0;
                        st         <= ST_IDLE;
                    end else if (ev.scl_fall) begin
                        tx         <= reply_byte(dev_addr_i);
                        cnt        <= 3'd7;
                        sda_pull_o <= ~dev_addr_i[ADDR_W-1];
                        st         <= ST_DATA;
                    end
                    ST_DATA: if (!pending_i) begin
                        sda_pull_o <= 1'b0;
                        st         <= ST_IDLE;
                    end else if (ev.scl_rise) begin
                        if (cnt != 3'd0 && !sda_pull_o && !ev.sda)
                            st <= ST_IDLE;
                    end else if (ev.scl_fall) begin
                        if (cnt == 3'd0) begin
                            sda_pull_o <= 1'b0;
                            win_o      <= 1'b1;
                            st         <= ST_NACK;
                        end else begin
                            cnt        <= cnt - 3'd1;
                            sda_pull_o <= ~tx[cnt - 3'd1];
                        end
                    end
                    ST_NACK: sda_pull_o <= 1'b0;
                    default: begin
                        st         <= ST_IDLE;
                        sda_pull_o <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_alert_resp.sv
module smb_alert_resp
    import smba_pkg::*;
#(
    parameter int N_STATUS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [N_STATUS-1:0] status_i,
    input  logic [N_STATUS-1:0] enable_i,
    input  logic [ADDR_W-1:0]   dev_addr_i,
    input  logic                clear_i,
    output logic                sda_pull_o,
    output logic                alert_pull_o,
    output logic [N_STATUS-1:0] status_q_o
);
    bus_ev_t ev;
    logic    pending;
    logic    win;

    smba_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    smba_status #(.N_STATUS(N_STATUS)) u_status (
        .clk        (clk),
        .rst        (rst),
        .status_i   (status_i),
        .enable_i   (enable_i),
        .clear_i    (clear_i),
        .win_i      (win),
        .status_q_o (status_q_o),
        .pending_o  (pending)
    );

    smba_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .pending_i  (pending),
        .dev_addr_i (dev_addr_i),
        .sda_pull_o (sda_pull_o),
        .win_o      (win)
    );

    assign alert_pull_o = pending;
endmodule

// File: rtl/smba_checker.sv
module smba_checker #(
    parameter int N_STATUS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [N_STATUS-1:0] status_i,
    input logic [N_STATUS-1:0] enable_i,
    input logic                clear_i,
    input logic [N_STATUS-1:0] status_q_o,
    input logic                alert_pull_o,
    input logic                sda_pull_o
);
    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((status_q_o & $past(status_i)) == $past(status_i)));

    p_status_keep_r6: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((status_q_o & $past(status_q_o)) == $past(status_q_o)));

    p_raise_r1: assert property (@(posedge clk) disable iff (rst)
        ((|(status_i & enable_i & ~status_q_o)) && !clear_i) |=> alert_pull_o);

    p_rise_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(alert_pull_o) |-> $past(|(status_i & enable_i & ~status_q_o)));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (status_q_o == '0 && !alert_pull_o));

    p_abandon_r9: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_o && !alert_pull_o) |=> !sda_pull_o);

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(alert_pull_o) && !$past(clear_i)) |-> !sda_pull_o);
endmodule

bind smb_alert_resp smba_checker #(.N_STATUS(N_STATUS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .status_i     (status_i),
    .enable_i     (enable_i),
    .clear_i      (clear_i),
    .status_q_o   (status_q_o),
    .alert_pull_o (alert_pull_o),
    .sda_pull_o   (sda_pull_o)
);

// File: tb/sim_smb_alert_resp.sv
module sim_smb_alert_resp;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 8;
    localparam int N          = 8;
    localparam logic [6:0] MY_ADDR = 7'h35;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         h_scl = 1'b1, h_sda = 1'b1, oth_pull = 1'b0;
    logic [N-1:0] st_in = '0;
    logic [N-1:0] en = 8'h7F;
    logic         clr = 1'b0;
    logic         dut_sda, dut_alert;
    logic [N-1:0] dut_stat;
    logic         sda_bus;
    logic [N-1:0] m_stat;
    int           n_cmp = 0, n_bad = 0;
    bit           done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = h_sda & ~dut_sda & ~oth_pull;

    smb_alert_resp #(.N_STATUS(N)) u0 (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (h_scl),
        .sda_i        (sda_bus),
        .status_i     (st_in),
        .enable_i     (en),
        .dev_addr_i   (MY_ADDR),
        .clear_i      (clr),
        .sda_pull_o   (dut_sda),
        .alert_pull_o (dut_alert),
        .status_q_o   (dut_stat)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // behavioural model of the sticky status register (R1, R10)
    always @(posedge clk) begin
        if (rst || clr) m_stat <= '0;
        else            m_stat <= m_stat | st_in;
    end

    always @(negedge clk) begin
        if (!rst) check(dut_stat == m_stat, "R1 status", int'(dut_stat), int'(m_stat));
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        h_sda = 1'b1; wn(H);
        h_scl = 1'b1; wn(H);
        h_sda = 1'b0; wn(H);
        h_scl = 1'b0; wn(H);
    endtask

    task automatic bus_stop();
        h_sda = 1'b0; wn(H);
        h_scl = 1'b1; wn(H);
        h_sda = 1'b1; wn(H);
    endtask

    task automatic write_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            h_sda = b[i]; wn(H);
            h_scl = 1'b1; wn(H);
            h_scl = 1'b0;
        end
        h_sda = 1'b1; wn(H);
        h_scl = 1'b1; wn(H/2);
        acked = !sda_bus;
        wn(H/2);
        h_scl = 1'b0;
    endtask

    task automatic read_bits(input int first, input int last, input bit has_comp,
                             input logic [6:0] comp, output logic [7:0] got,
                             output logic [7:0] pulls);
        bit comp_lost = !has_comp;
        got = '1;
        pulls = '0;
        for (int i = first; i >= last; i--) begin
            h_sda = 1'b1;
            oth_pull = !comp_lost && (i > 0) && !comp[(i > 0) ? i-1 : 0];
            wn(H);
            h_scl = 1'b1; wn(H/2);
            got[i] = sda_bus;
            pulls[i] = dut_sda;
            if (!comp_lost && i > 0 && comp[i-1] && !sda_bus) comp_lost = 1;
            wn(H/2);
            h_scl = 1'b0;
        end
        oth_pull = 1'b0;
    endtask

    task automatic ara_read(input bit has_comp, input logic [6:0] comp, output bit acked,
                            output logic [7:0] got, output logic [7:0] pulls,
                            output bit alert_nack);
        bus_start();
        write_byte(8'h19, acked);
        got = '1;
        pulls = '0;
        alert_nack = dut_alert;
        if (acked) begin
            read_bits(7, 0, has_comp, comp, got, pulls);
            h_sda = 1'b1; wn(H);
            h_scl = 1'b1; wn(H/2);
            alert_nack = dut_alert;
            wn(H/2);
            h_scl = 1'b0;
        end
        bus_stop();
    endtask

    initial begin
        bit ack, an;
        logic [7:0] got, pulls;
        wn(5);
        rst = 1'b0;
        wn(1);
        check(dut_alert == 0, "R1 reset alert", dut_alert, 0);
        check(dut_sda == 0, "R1 reset sda", dut_sda, 0);
        check(dut_stat == 0, "R1 reset status", int'(dut_stat), 0);

        // R2: disabled bit 7
        st_in[7] = 1'b1; wn(3);
        check(dut_alert == 0, "R2 disabled no alert", dut_alert, 0);
        check(dut_stat[7] == 1, "R2 disabled latched", dut_stat[7], 1);

        // R1: enabled bit 0 raises the alert one edge later
        st_in[0] = 1'b1; wn(1);
        check(dut_alert == 1, "R1 alert raised", dut_alert, 1);

        // R3 R4 R5: uncontested response
        ara_read(0, 7'h00, ack, got, pulls, an);
        check(ack == 1, "R3 ack", ack, 1);
        check(got == {MY_ADDR, 1'b1}, "R4 data byte", got, {MY_ADDR, 1'b1});
        check(an == 0, "R5 released in nack", an, 0);

        // R6: stays released, status unchanged
        wn(20);
        check(dut_alert == 0, "R6 alert stays off", dut_alert, 0);
        check(dut_stat == 8'h81, "R6 status kept", int'(dut_stat), 8'h81);

        // R7: latched bit toggling does not re-trigger; new bit does
        st_in[0] = 1'b0; wn(2);
        st_in[0] = 1'b1; wn(2);
        check(dut_alert == 0, "R7 no retrigger", dut_alert, 0);
        st_in[1] = 1'b1; wn(1);
        check(dut_alert == 1, "R7 new bit alert", dut_alert, 1);

        // R8: lower competitor 0x21 wins; loss at bit 5
        ara_read(1, 7'h21, ack, got, pulls, an);
        check(ack == 1, "R8 ack", ack, 1);
        check(got == 8'h43, "R8 lower addr read", got, 8'h43);
        check(pulls[4] == 0 && pulls[2] == 0, "R8 silent after loss", int'(pulls), 0);
        check(an == 1, "R8 alert kept", an, 1);
        wn(4);
        check(dut_alert == 1, "R8 alert kept after", dut_alert, 1);

        // R8: higher competitor 0x5A loses
        ara_read(1, 7'h5A, ack, got, pulls, an);
        check(got == {MY_ADDR, 1'b1}, "R8 beats higher", got, {MY_ADDR, 1'b1});
        check(an == 0, "R8 winner releases", an, 0);

        // R9: no pending -> no ack
        ara_read(0, 7'h00, ack, got, pulls, an);
        check(ack == 0, "R9 no ack idle", ack, 0);

        // R9: mismatched address bytes
        st_in[2] = 1'b1; wn(1);
        check(dut_alert == 1, "R9 alert set", dut_alert, 1);
        bus_start(); write_byte(8'h18, ack); bus_stop();
        check(ack == 0, "R9 write dir ignored", ack, 0);
        bus_start(); write_byte(8'h45, ack); bus_stop();
        check(ack == 0, "R9 other addr ignored", ack, 0);

        // R11: STOP mid-byte aborts
        bus_start(); write_byte(8'h19, ack);
        check(ack == 1, "R11 ack", ack, 1);
        read_bits(7, 6, 0, 7'h00, got, pulls);
        bus_stop(); wn(4);
        check(dut_sda == 0, "R11 sda released", dut_sda, 0);
        check(dut_alert == 1, "R11 alert kept", dut_alert, 1);
        ara_read(0, 7'h00, ack, got, pulls, an);
        check(ack == 1 && got == {MY_ADDR, 1'b1}, "R11 next read", got, {MY_ADDR, 1'b1});

        // R10: clear with bit 2 still high
        st_in = 8'h04;
        clr = 1'b1; wn(1);
        clr = 1'b0;
        check(dut_stat == 0, "R10 cleared", int'(dut_stat), 0);
        check(dut_alert == 0, "R10 alert dropped", dut_alert, 0);
        wn(1);
        check(dut_alert == 1, "R10 fresh alert", dut_alert, 1);
        wn(4);
        finish_run();
    end
endmodule